// File: doc/BRIEF.md
# Software Write-Protect Key Detector

This block sits in front of the page-write path of a byte-wide nonvolatile array. It sees every write strobe with its address and data byte. It keeps one protection flag. Under that flag, array writes are dropped unless a keyed unlock sequence comes first.

Three writes form the unlock key. The unlock key also turns protection on. It opens a one-page data window, and protection stays on after the window closes. Six writes form the release key, which clears the flag.

For every strobe the block gives a pass or suppress decision one cycle later. Key bytes are always suppressed, so they never reach the array. A separate input pulses when the page-load timer of the write path expires. That pulse ends the burst. It also drops any partly matched key and closes the data window.

The flag is held in a register whose reset value is a parameter. In this way the block can stand in for a flag that survives power loss. The current key step is visible on an output, so partial sequences can be observed.

Top module: `sdp_guard`

## Requirements
- R1: `dec_vld_o` is high in exactly the cycle after each cycle with `wr_valid_i` high. When `dec_vld_o` is low, `dec_pass_o` is also low.
- R2: `step_o` uses this encoding. 0 means idle. 1 to 5 count the key writes matched so far. 6 means the data window is open. The unlock key is AAh at address 1555h, then 55h at 0AAAh, then A0h at 1555h. The release key is AAh@1555h, 55h@0AAAh, 80h@1555h, AAh@1555h, 55h@0AAAh, 20h@1555h. Each matched key write moves `step_o` up by one.
- R3: A write that matches the next key step, or completes a key, gets `dec_pass_o` = 0.
- R4: With protection off, a write that is neither a key write nor inside a window gets `dec_pass_o` = 1.
- R5: With protection on, a write outside a data window gets `dec_pass_o` = 0.
- R6: After the unlock key, at most PAGE_BYTES window writes pass (64 by default). The first window write fixes the page tag, which is address bits [12:6]. Later writes with a different tag, and writes beyond PAGE_BYTES, are suppressed and do not use up a slot.
- R7: A completed unlock key sets `prot_o` in the cycle after the `tmo_i` pulse that closes its window. `prot_o` never rises at any other time.
- R8: The sixth write of the release key clears `prot_o`, visible in the next cycle. Later ordinary writes in the same burst then pass.
- R9: A write that does not match the expected key step returns the matcher to idle. It is then checked again as the first write of a key. If it is not, it is handled as an ordinary write.
- R10: A `tmo_i` pulse closes the window and sends the matcher to idle. A write in the same cycle as `tmo_i` is handled as arriving after the timeout.
- R11: After reset, `prot_o` equals the parameter PROT_RST, `step_o` is 0 and `dec_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | One-cycle write strobe |
| wr_addr_i | input | ADDR_W (13) | Write address |
| wr_data_i | input | DATA_W (8) | Write data byte |
| tmo_i | input | 1 | Page-load timer expired, ends the burst |
| prot_o | output | 1 | Protection flag |
| dec_vld_o | output | 1 | Decision valid, one cycle after the strobe |
| dec_pass_o | output | 1 | 1 = forward the write to the array, 0 = suppress it |
| step_o | output | 3 | Key step: 0 idle, 1..5 partial key, 6 window open |

## Verification
The assertions assume that `wr_valid_i` and `tmo_i` are held low during reset and are clean one-cycle pulses. They also assume that `tmo_i` comes only from the write path's timer. Under these assumptions, a rise of the flag can be traced to a timeout and a fall to the final release write.

The stimulus drives all inputs on the falling edge. It pulses `tmo_i` only between bursts, except for one deliberate case where it coincides with a write. That case lands in the same cycle as a key step, so the timeout-first rule is exercised under the same conditions.

// File: rtl/sdp_guard_pkg.sv
package sdp_guard_pkg;
  localparam int STEP_W = 3;

  typedef enum logic [STEP_W-1:0] {
    STP_IDLE = 3'd0,
    STP_K1   = 3'd1,
    STP_K2   = 3'd2,
    STP_K3   = 3'd3,
    STP_K4   = 3'd4,
    STP_K5   = 3'd5,
    STP_WIN  = 3'd6
  } step_e;

  localparam logic [7:0] KD_LEAD   = 8'hAA;
  localparam logic [7:0] KD_FOLLOW = 8'h55;
  localparam logic [7:0] KD_LOCK   = 8'hA0;
  localparam logic [7:0] KD_ESC    = 8'h80;
  localparam logic [7:0] KD_FREE   = 8'h20;

  // key addresses are the alternating patterns truncated to the address width
  localparam logic [31:0] KA_ODD_PAT  = 32'h5555_5555;
  localparam logic [31:0] KA_EVEN_PAT = 32'hAAAA_AAAA;
endpackage

// File: rtl/sdp_key_match.sv
module sdp_key_match
  import sdp_guard_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  step_e             step_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              hit_o,
  output step_e             nxt_o,
  output logic              lock_o,
  output logic              free_o
);
  localparam logic [ADDR_W-1:0] A_ODD  = KA_ODD_PAT[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_EVEN = KA_EVEN_PAT[ADDR_W-1:0];

  logic at_odd, at_even;
  logic d_lead, d_follow, d_lock, d_esc, d_free;

  assign at_odd   = (addr_i == A_ODD);
  assign at_even  = (addr_i == A_EVEN);
  assign d_lead   = (data_i == DATA_W'(KD_LEAD));
  assign d_follow = (data_i == DATA_W'(KD_FOLLOW));
  assign d_lock   = (data_i == DATA_W'(KD_LOCK));
  assign d_esc    = (data_i == DATA_W'(KD_ESC));
  assign d_free   = (data_i == DATA_W'(KD_FREE));

  always_comb begin
    hit_o  = 1'b0;
    nxt_o  = STP_IDLE;
    lock_o = 1'b0;
    free_o = 1'b0;
    unique case (step_i)
      STP_IDLE: if (at_odd && d_lead) begin
        hit_o = 1'b1;
        nxt_o = STP_K1;
      end
      STP_K1: if (at_even && d_follow) begin
        hit_o = 1'b1;
        nxt_o = STP_K2;
      end
      STP_K2: if (at_odd && d_lock) begin
        hit_o  = 1'b1;
        lock_o = 1'b1;
      end else if (at_odd && d_esc) begin
        hit_o = 1'b1;
        nxt_o = STP_K3;
      end
      STP_K3: if (at_odd && d_lead) begin
        hit_o = 1'b1;
        nxt_o = STP_K4;
      end
      STP_K4: if (at_even && d_follow) begin
        hit_o = 1'b1;
        nxt_o = STP_K5;
      end
      STP_K5: if (at_odd && d_free) begin
        hit_o  = 1'b1;
        free_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdp_page_win.sv
module sdp_page_win #(
  parameter int TAG_W      = 7,
  parameter int PAGE_BYTES = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             close_i,
  input  logic             wr_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             win_o,
  output logic             eff_o,
  output logic             acc_o
);
  localparam int CNT_W = $clog2(PAGE_BYTES + 1);

  logic             win_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TAG_W-1:0] tag_q;
  logic             room, first;

  assign eff_o = win_q & ~close_i;
  assign room  = cnt_q < CNT_W'(PAGE_BYTES);
  assign first = (cnt_q == '0);
  assign acc_o = wr_i & eff_o & room & (first | (tag_i == tag_q));
  assign win_o = win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= 1'b0;
      cnt_q <= '0;
      tag_q <= '0;
    end else begin
      if (close_i) win_q <= 1'b0;
      if (open_i) begin
        win_q <= 1'b1;
        cnt_q <= '0;
      end else if (acc_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (first) tag_q <= tag_i;
      end
    end
  end
endmodule

// File: rtl/sdp_prot_reg.sv
module sdp_prot_reg #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic prot_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prot_o <= RST_VAL;
    else if (clr_i) prot_o <= 1'b0;
    else if (set_i) prot_o <= 1'b1;
  end
endmodule

// File: rtl/sdp_guard.sv
module sdp_guard
  import sdp_guard_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 64,
  parameter bit PROT_RST   = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tmo_i,
  output logic              prot_o,
  output logic              dec_vld_o,
  output logic              dec_pass_o,
  output logic [STEP_W-1:0] step_o
);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int TAG_W  = ADDR_W - OFS_W;
  localparam int NPROBE = 2;

  step_e step_q, step_d, st_cur;
  logic  win_q, win_eff, win_acc;
  logic  prot_q, prot_eff, tmo_win;
  logic  key_wr, pass_d;
  logic  kw_hit, kw_lock, kw_free;
  step_e kw_nxt;

  step_e probe_st [NPROBE];
  logic  hit_v    [NPROBE];
  step_e nxt_v    [NPROBE];
  logic  lock_v   [NPROBE];
  logic  free_v   [NPROBE];

  // a timeout is taken before a write in the same cycle
  assign st_cur      = tmo_i ? STP_IDLE : step_q;
  assign probe_st[0] = st_cur;
  assign probe_st[1] = STP_IDLE;  // restart after a broken sequence

  for (genvar g = 0; g < NPROBE; g++) begin : g_probe
    sdp_key_match #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
    ) u_match (
      .step_i(probe_st[g]),
      .addr_i(wr_addr_i),
      .data_i(wr_data_i),
      .hit_o (hit_v[g]),
      .nxt_o (nxt_v[g]),
      .lock_o(lock_v[g]),
      .free_o(free_v[g])
    );
  end

  assign kw_hit  = hit_v[0] | hit_v[1];
  assign kw_nxt  = hit_v[0] ? nxt_v[0]  : nxt_v[1];
  assign kw_lock = hit_v[0] ? lock_v[0] : lock_v[1];
  assign kw_free = hit_v[0] ? free_v[0] : free_v[1];

  assign key_wr   = wr_valid_i & ~win_eff & kw_hit;
  assign tmo_win  = tmo_i & win_q;
  assign prot_eff = prot_q | tmo_win;

  always_comb begin
    step_d = step_q;
    if (tmo_i) step_d = STP_IDLE;
    if (wr_valid_i && !win_eff) begin
      if (key_wr && !kw_lock && !kw_free) step_d = kw_nxt;
      else                                step_d = STP_IDLE;
    end
  end

  assign pass_d = wr_valid_i & (win_eff ? win_acc : (~key_wr & ~prot_eff));

  sdp_page_win #(
    .TAG_W     (TAG_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .open_i (key_wr & kw_lock),
    .close_i(tmo_i),
    .wr_i   (wr_valid_i),
    .tag_i  (wr_addr_i[ADDR_W-1:OFS_W]),
    .win_o  (win_q),
    .eff_o  (win_eff),
    .acc_o  (win_acc)
  );

  sdp_prot_reg #(
    .RST_VAL(PROT_RST)
  ) u_prot (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (tmo_win),
    .clr_i (key_wr & kw_free),
    .prot_o(prot_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q     <= STP_IDLE;
      dec_vld_o  <= 1'b0;
      dec_pass_o <= 1'b0;
    end else begin
      step_q     <= step_d;
      dec_vld_o  <= wr_valid_i;
      dec_pass_o <= pass_d;
    end
  end

  assign prot_o = prot_q;
  assign step_o = win_q ? STP_WIN : step_q;
endmodule

// File: rtl/sdp_guard_chk.sv
module sdp_guard_chk
  import sdp_guard_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic              tmo_i,
  input logic              prot_o,
  input logic              dec_vld_o,
  input logic              dec_pass_o,
  input logic [STEP_W-1:0] step_o
);
  // R1
  dec_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> dec_vld_o);

  // R1
  dec_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> (!dec_vld_o && !dec_pass_o));

  // R2
  step_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o != $past(step_o) && step_o >= 3'd2 && step_o <= 3'd5)
      |-> (step_o == $past(step_o) + 3'd1));

  // R3
  key_sup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_valid_i) && step_o >= 3'd1 && step_o <= 3'd5) |-> !dec_pass_o);

  // R5
  prot_sup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && prot_o && step_o != 3'd6) |=> !dec_pass_o);

  // R7
  prot_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prot_o) |-> $past(tmo_i));

  // R8
  prot_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prot_o) |-> ($past(wr_valid_i) && !$past(tmo_i) && $past(step_o) == 3'd5));

  // R10
  tmo_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_i && !wr_valid_i) |=> (step_o == 3'd0));
endmodule

bind sdp_guard sdp_guard_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_valid_i(wr_valid_i),
  .tmo_i     (tmo_i),
  .prot_o    (prot_o),
  .dec_vld_o (dec_vld_o),
  .dec_pass_o(dec_pass_o),
  .step_o    (step_o)
);

// File: tb/sdp_guard_bench.sv
`timescale 1ns/1ps
module sdp_guard_bench;
  localparam int PAGE = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_v = 1'b0;
  logic [12:0] wr_a = '0;
  logic [7:0]  wr_d = '0;
  logic        tmo = 1'b0;

  logic       prot, vld, pass;
  logic [2:0] step;
  logic       prot_p, vld_p, pass_p;
  logic [2:0] step_p;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdp_guard u_sdp_guard (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_v), .wr_addr_i(wr_a),
    .wr_data_i(wr_d), .tmo_i(tmo), .prot_o(prot), .dec_vld_o(vld),
    .dec_pass_o(pass), .step_o(step)
  );

  sdp_guard #(.PROT_RST(1'b1)) u_sdp_guard_p (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(1'b0), .wr_addr_i(13'h0),
    .wr_data_i(8'h0), .tmo_i(1'b0), .prot_o(prot_p), .dec_vld_o(vld_p),
    .dec_pass_o(pass_p), .step_o(step_p)
  );

  // behavioural reference
  int m_step, m_cnt, m_tag;
  bit m_win, m_prot, e_vld, e_pass;
  int rel_a [6] = '{'h1555, 'h0AAA, 'h1555, 'h1555, 'h0AAA, 'h1555};
  int rel_d [6] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h20};

  // -1 no match, 1..5 next step, 10 unlock done, 11 release done
  function automatic int key_eval(int s, int a, int d);
    if (s == 2 && a == 'h1555 && d == 'hA0) return 10;
    if (s < 6 && a == rel_a[s] && d == rel_d[s]) return (s == 5) ? 11 : s + 1;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; m_cnt = 0; m_tag = 0; m_win = 0; m_prot = 0;
      e_vld = 0; e_pass = 0;
    end else begin
      int r;
      e_vld = wr_v;
      e_pass = 0;
      if (tmo) begin
        if (m_win) m_prot = 1;
        m_win = 0;
        m_step = 0;
      end
      if (wr_v) begin
        if (m_win) begin
          if (m_cnt < PAGE && (m_cnt == 0 || (int'(wr_a) >> 6) == m_tag)) begin
            if (m_cnt == 0) m_tag = int'(wr_a) >> 6;
            m_cnt++;
            e_pass = 1;
          end
        end else begin
          r = key_eval(m_step, int'(wr_a), int'(wr_d));
          if (r < 0 && m_step != 0) r = key_eval(0, int'(wr_a), int'(wr_d));
          if (r < 0) begin
            m_step = 0;
            e_pass = !m_prot;
          end else if (r == 10) begin
            m_step = 0; m_win = 1; m_cnt = 0;
          end else if (r == 11) begin
            m_step = 0; m_prot = 0;
          end else begin
            m_step = r;
          end
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 dec_vld_o", int'(vld), int'(e_vld));
      chk("R5 dec_pass_o", int'(pass), int'(e_pass));
      chk("R7 prot_o", int'(prot), int'(m_prot));
      chk("R2 step_o", int'(step), m_win ? 6 : m_step);
    end
  end

  task automatic wr(int a, int d, bit t = 1'b0);
    wr_v = 1'b1; wr_a = 13'(a); wr_d = 8'(d); tmo = t;
    @(negedge clk);
    wr_v = 1'b0; tmo = 1'b0;
  endtask

  task automatic pulse_tmo();
    tmo = 1'b1;
    @(negedge clk);
    tmo = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end

  initial begin
    int npass;
    repeat (3) @(negedge clk);
    chk("R11 prot reset", int'(prot), 0);
    chk("R11 prot reset PROT_RST=1", int'(prot_p), 1);
    chk("R11 step reset", int'(step), 0);
    chk("R1 vld reset", int'(vld), 0);
    rst_n = 1'b1;
    idle(2);

    // unprotected ordinary writes
    wr('h0123, 'h5A); chk("R4 plain write passes", int'(pass), 1);
    wr('h1555, 'h12); chk("R4 key addr, other data", int'(pass), 1);
    chk("R9 no key step", int'(step), 0);
    pulse_tmo();

    // unlock key while unprotected, then one page
    wr('h1555, 'hAA); chk("R2 step 1", int'(step), 1); chk("R3 key byte dropped", int'(pass), 0);
    wr('h0AAA, 'h55); chk("R2 step 2", int'(step), 2);
    wr('h1555, 'hA0); chk("R2 window open", int'(step), 6); chk("R3 last key byte dropped", int'(pass), 0);
    chk("R7 not yet protected", int'(prot), 0);
    wr('h0240, 'h01); chk("R6 window first byte", int'(pass), 1);
    wr('h0241, 'h02); chk("R6 window same page", int'(pass), 1);
    wr('h0300, 'h03); chk("R6 other page dropped", int'(pass), 0);
    pulse_tmo();
    chk("R7 protected at burst end", int'(prot), 1);
    chk("R10 step idle after timeout", int'(step), 0);

    // protected plain write
    wr('h0100, 'h07); chk("R5 protected write dropped", int'(pass), 0);
    idle(3);
    chk("R7 flag sticky", int'(prot), 1);
    pulse_tmo();

    // unlock and a full page plus one
    wr('h1555, 'hAA); wr('h0AAA, 'h55); wr('h1555, 'hA0);
    npass = 0;
    for (int i = 0; i < PAGE; i++) begin
      wr('h0400 + i, i);
      if (pass) npass++;
    end
    chk("R6 full page passes", npass, PAGE);
    wr('h0400, 'hEE); chk("R6 beyond page dropped", int'(pass), 0);
    pulse_tmo();
    chk("R7 still protected", int'(prot), 1);

    // partial key broken by timeout
    wr('h1555, 'hAA); wr('h0AAA, 'h55);
    chk("R2 partial at 2", int'(step), 2);
    pulse_tmo();
    chk("R10 partial dropped", int'(step), 0);
    wr('h1555, 'hA0); chk("R10 late third byte dropped", int'(pass), 0);
    chk("R10 no window", int'(step), 0);
    pulse_tmo();

    // break and restart
    wr('h1555, 'hAA); wr('h1555, 'hAA);
    chk("R9 restart at step 1", int'(step), 1);
    wr('h0AAA, 'h12); chk("R9 broken to idle", int'(step), 0);
    chk("R5 broken write dropped", int'(pass), 0);
    pulse_tmo();

    // release key
    wr('h1555, 'hAA); wr('h0AAA, 'h55); wr('h1555, 'h80);
    chk("R2 release step 3", int'(step), 3);
    wr('h1555, 'hAA); wr('h0AAA, 'h55);
    chk("R2 release step 5", int'(step), 5);
    chk("R8 still protected before last", int'(prot), 1);
    wr('h1555, 'h20);
    chk("R8 released", int'(prot), 0); chk("R3 release byte dropped", int'(pass), 0);
    wr('h0050, 'h09); chk("R8 same burst write passes", int'(pass), 1);
    pulse_tmo();

    // write coinciding with timeout
    wr('h1555, 'hAA); chk("R2 step 1 again", int'(step), 1);
    wr('h0AAA, 'h55, 1'b1);
    chk("R10 write with timeout restarts", int'(step), 0);
    chk("R10 write with timeout is ordinary", int'(pass), 1);

    // unprotected break
    wr('h1555, 'hAA); wr('h0001, 'h44);
    chk("R9 break passes unprotected", int'(pass), 1);
    chk("R9 idle after break", int'(step), 0);
    idle(3);
    finish_run();
  end
endmodule